// File: doc/BRIEF.md
# SWD Line Sequence Generator

This block drives the clock and data lines of a two-wire serial debug port to play back line-level sequences that sit outside normal register transactions. Examples are the line reset, the switches between the serial-wire and boundary-scan protocols, and the run of idle clocks that follows a transaction or a protocol switch. The host loads up to eight 32-bit pattern words and then pulses `start`. With the start pulse it gives a bit count and selects either pattern replay or idle strobing.

In pattern mode, the bits leave least-significant first. Bit k of the sequence is bit k mod 32 of word k / 32. In idle mode, the data line is held low for the requested number of full clock pulses. Every clock pulse is a low half-period, during which the data value is set up, followed by a high half-period. The half-period is a parameter counted in system clocks. At the end of each operation both lines rest high and `done` pulses for one cycle.

The sequence contents are the host's business. After a switch to the serial-wire protocol, the host issues an 8-pulse idle operation itself.

Top module: `swd_seq_gen`

## Requirements
- R1: While reset is asserted and after its release, `swclk` and `swdio_o` are 1, `swdio_oe` is 1, and `busy` and `done` are 0.
- R2: In pattern mode (`idle_mode` = 0), the k-th bit driven on `swdio_o` (k from 0) equals bit (k mod 32) of the pattern word written at address k / 32. Words are written by holding `pat_we` high for one cycle with `pat_addr` and `pat_wdata`.
- R3: Each transmitted bit is a low phase of `swclk` lasting exactly HALF_CYC cycles, then a high phase of HALF_CYC cycles. `swdio_o` changes only in the cycle where `swclk` falls, so the value is stable across the rising edge.
- R4: In idle mode (`idle_mode` = 1), exactly `seq_len` clock pulses are produced and `swdio_o` is 0 at every rising edge of `swclk`.
- R5: An operation with N > 0 raises `done` for exactly one cycle, 2·N·HALF_CYC cycles after the edge that accepted `start`. In that cycle `swclk` and `swdio_o` are both 1.
- R6: A start with `seq_len` = 0, in either mode, raises `done` in the cycle after acceptance and produces no clock pulse.
- R7: A `start` pulse while `busy` is 1 is ignored. The running operation keeps its length, mode and timing.
- R8: `busy` is 1 from the cycle after an accepted start with N > 0 until the cycle `done` rises, when it is 0. While `busy` is 0, `swclk` and `swdio_o` are 1.
- R9: A pattern of up to 255 bits crosses word boundaries without any gap or extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pat_we | input | 1 | Pattern word write strobe |
| pat_addr | input | 3 | Pattern word index |
| pat_wdata | input | 32 | Pattern word value |
| start | input | 1 | One-cycle operation request |
| idle_mode | input | 1 | 1 = idle strobing, 0 = pattern replay |
| seq_len | input | 8 | Bit count or idle pulse count |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| swclk | output | 1 | Serial debug clock |
| swdio_o | output | 1 | Serial debug data out |
| swdio_oe | output | 1 | Data output enable, always 1 |

## Verification
Four properties are checked on every cycle:
- the exact low-phase length of `swclk`;
- that data moves only on a falling clock while busy;
- that both lines rest high whenever the engine is idle;
- that `done` is a single-cycle pulse with both lines high, which only follows a start or a busy period.

Other behaviour needs known stimulus, so only the directed scenarios can show it:
- the order in which the pattern bits come out across word boundaries;
- the pulse count of idle runs;
- the total latency;
- the zero-length shortcut;
- that a start issued mid-operation is ignored.

// File: rtl/swd_seq_pkg.sv
`timescale 1ns/1ps
package swd_seq_pkg;
    typedef enum logic [1:0] {
        ST_REST = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } seq_state_e;
endpackage

// File: rtl/swd_pat_buf.sv
`timescale 1ns/1ps
module swd_pat_buf #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 8,
    localparam int BIT_W    = $clog2(WORD_W),
    localparam int WSEL_W   = $clog2(NUM_WORDS),
    localparam int IDX_W    = BIT_W + WSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WSEL_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic              rbit
);
    logic [WORD_W-1:0] word_d [NUM_WORDS];
    logic [WORD_W-1:0] word_q [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_comb begin
            word_d[w] = word_q[w];
            if (we && (waddr == WSEL_W'(w))) word_d[w] = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q[w] <= '0;
            else        word_q[w] <= word_d[w];
        end
    end

    // Word select from the upper index bits, bit select from the lower ones.
    logic [WORD_W-1:0] sel_word;
    assign sel_word = word_q[ridx[IDX_W-1:BIT_W]];
    assign rbit     = sel_word[ridx[BIT_W-1:0]];
endmodule

// File: rtl/swd_half_timer.sv
`timescale 1ns/1ps
module swd_half_timer #(
    parameter int HALF_CYC = 94,
    localparam int TW      = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    logic [TW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == TW'(HALF_CYC - 1));

    always_comb begin
        cnt_d = cnt_q + TW'(1);
        if (!run || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/swd_seq_engine.sv
`timescale 1ns/1ps
module swd_seq_engine
    import swd_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             idle_mode,
    input  logic [CNT_W-1:0] seq_len,
    input  logic             tick,
    input  logic             pat_bit,
    output logic [CNT_W-1:0] bit_idx,
    output logic             run,
    output logic             done,
    output logic             swclk,
    output logic             swdio
);
    typedef struct packed {
        seq_state_e       st;
        logic             idle_op;
        logic [CNT_W-1:0] left;
        logic [CNT_W-1:0] idx;
        logic             clk_o;
        logic             dio_o;
        logic             done;
    } eng_t;

    eng_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_REST: begin
                if (start) begin
                    if (seq_len == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.st      = ST_LOW;
                        d.idle_op = idle_mode;
                        d.left    = seq_len;
                        d.clk_o   = 1'b0;
                        d.dio_o   = idle_mode ? 1'b0 : pat_bit;
                        d.idx     = q.idx + CNT_W'(1);
                    end
                end
            end
            ST_LOW: begin
                if (tick) begin
                    d.st    = ST_HIGH;
                    d.clk_o = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (q.left == CNT_W'(1)) begin
                        d.st    = ST_REST;
                        d.dio_o = 1'b1;
                        d.done  = 1'b1;
                        d.idx   = '0;
                        d.left  = '0;
                    end else begin
                        d.st    = ST_LOW;
                        d.left  = q.left - CNT_W'(1);
                        d.clk_o = 1'b0;
                        d.dio_o = q.idle_op ? 1'b0 : pat_bit;
                        d.idx   = q.idx + CNT_W'(1);
                    end
                end
            end
            default: d.st = ST_REST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_REST;
            q.idle_op <= 1'b0;
            q.left    <= '0;
            q.idx     <= '0;
            q.clk_o   <= 1'b1;
            q.dio_o   <= 1'b1;
            q.done    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign bit_idx = q.idx;
    assign run     = (q.st != ST_REST);
    assign done    = q.done;
    assign swclk   = q.clk_o;
    assign swdio   = q.dio_o;
endmodule

// File: rtl/swd_seq_gen.sv
`timescale 1ns/1ps
module swd_seq_gen #(
    parameter int HALF_CYC  = 94,
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 8,
    localparam int WSEL_W   = $clog2(NUM_WORDS),
    localparam int CNT_W    = $clog2(WORD_W * NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pat_we,
    input  logic [WSEL_W-1:0] pat_addr,
    input  logic [WORD_W-1:0] pat_wdata,
    input  logic              start,
    input  logic              idle_mode,
    input  logic [CNT_W-1:0]  seq_len,
    output logic              busy,
    output logic              done,
    output logic              swclk,
    output logic              swdio_o,
    output logic              swdio_oe
);
    logic [CNT_W-1:0] bit_idx;
    logic             pat_bit;
    logic             run;
    logic             tick;

    swd_pat_buf #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_buf (
        .clk(clk), .rst_n(rst_n), .we(pat_we), .waddr(pat_addr),
        .wdata(pat_wdata), .ridx(bit_idx), .rbit(pat_bit)
    );

    swd_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    swd_seq_engine #(.CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .idle_mode(idle_mode),
        .seq_len(seq_len), .tick(tick), .pat_bit(pat_bit), .bit_idx(bit_idx),
        .run(run), .done(done), .swclk(swclk), .swdio(swdio_o)
    );

    assign busy     = run;
    assign swdio_oe = 1'b1;
endmodule

// File: rtl/swd_seq_gen_chk.sv
`timescale 1ns/1ps
module swd_seq_gen_chk #(
    parameter int HALF_CYC = 94
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic swclk,
    input logic swdio_o
);
    int unsigned lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     lo_cnt <= 0;
        else if (swclk) lo_cnt <= 0;
        else            lo_cnt <= lo_cnt + 1;
    end

    // R3: low phase length measured by counter
    a_r3_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(swclk) |-> lo_cnt == HALF_CYC);

    // R3: data moves only together with a falling clock while busy
    a_r3_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$stable(swdio_o)) |-> $fell(swclk));

    // R8: lines rest high when not busy
    a_r8_rest_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (swclk && swdio_o));

    // R5: done is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: done follows an accepted start or a busy period
    a_r5_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) || $past(start)));

    // R8: busy never overlaps done
    a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind swd_seq_gen swd_seq_gen_chk #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .swclk(swclk), .swdio_o(swdio_o)
);

// File: tb/swd_seq_gen_test.sv
`timescale 1ns/1ps
module swd_seq_gen_test;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pat_we = 1'b0;
    logic [2:0]  pat_addr = '0;
    logic [31:0] pat_wdata = '0;
    logic        start = 1'b0;
    logic        idle_mode = 1'b0;
    logic [7:0]  seq_len = '0;
    logic        busy, done, swclk, swdio_o, swdio_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] words_tb [8];
    logic        bits [256];
    int          nbits = 0;
    int          phase_err = 0;
    int          glitch_err = 0;
    int          low_len = 0;
    logic        prev_clk = 1'b1;
    logic        prev_dio = 1'b1;

    swd_seq_gen #(.HALF_CYC(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .pat_we(pat_we), .pat_addr(pat_addr),
        .pat_wdata(pat_wdata), .start(start), .idle_mode(idle_mode),
        .seq_len(seq_len), .busy(busy), .done(done), .swclk(swclk),
        .swdio_o(swdio_o), .swdio_oe(swdio_oe)
    );

    always #2.5 clk = ~clk;

    // Line monitor: records the data value at each rising clock.
    always @(negedge clk) begin
        if (!prev_clk && swclk) begin
            if (nbits < 256) bits[nbits] = swdio_o;
            nbits = nbits + 1;
            if (low_len != HALF) phase_err = phase_err + 1;
        end
        if (!swclk) low_len = low_len + 1;
        else        low_len = 0;
        if (prev_clk && swclk && busy && (swdio_o != prev_dio)) glitch_err = glitch_err + 1;
        prev_clk = swclk;
        prev_dio = swdio_o;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_word(input int a, input logic [31:0] v);
        @(negedge clk);
        pat_we = 1'b1; pat_addr = 3'(a); pat_wdata = v;
        words_tb[a] = v;
        @(negedge clk);
        pat_we = 1'b0;
    endtask

    // Runs one operation; poke > 0 issues a second start that many cycles in.
    task automatic run_op(input bit idle, input int n, input int poke, input string req);
        int lat;
        int mism;
        int first_bad;
        @(negedge clk);
        idle_mode = idle; seq_len = 8'(n); start = 1'b1;
        nbits = 0; phase_err = 0; glitch_err = 0;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        check(busy == (n != 0), req, "R8 busy after start", int'(busy), int'(n != 0));
        while (!done && lat < 4000) begin
            if (poke > 0 && lat == poke) begin
                start = 1'b1; idle_mode = ~idle; seq_len = 8'd3;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat = lat + 1;
        end
        start = 1'b0;
        check(lat == 2 * n * HALF + 1, req, "R5 latency", lat, 2 * n * HALF + 1);
        check(swclk && swdio_o && !busy, req, "R5 lines high at done",
              int'({swclk, swdio_o, busy}), 6);
        check(nbits == n, req, "pulse count", nbits, n);
        check(phase_err == 0 && glitch_err == 0, req, "R3 phase timing",
              phase_err + glitch_err, 0);
        mism = 0; first_bad = -1;
        for (int k = 0; k < n && k < nbits; k++) begin
            logic e;
            e = idle ? 1'b0 : words_tb[k / 32][k % 32];
            if (bits[k] !== e) begin
                mism = mism + 1;
                if (first_bad < 0) first_bad = k;
            end
        end
        check(mism == 0, req, "bit values (mismatches / first index)", mism, 0);
        if (first_bad >= 0) $display("  first differing bit index %0d", first_bad);
        @(negedge clk);
        check(!done, req, "R5 done one cycle", int'(done), 0);
    endtask

    task automatic t_reset();
        check(swclk == 1'b1, "R1", "swclk", int'(swclk), 1);
        check(swdio_o == 1'b1, "R1", "swdio_o", int'(swdio_o), 1);
        check(swdio_oe == 1'b1, "R1", "swdio_oe", int'(swdio_oe), 1);
        check(!busy && !done, "R1", "busy/done", int'({busy, done}), 0);
    endtask

    task automatic t_short_pattern();
        write_word(0, 32'h0000_E79E);
        run_op(1'b0, 16, 0, "R2");
    endtask

    task automatic t_cross_word();
        write_word(0, 32'hA5C3_0F81);
        write_word(1, 32'h1357_9BDF);
        run_op(1'b0, 50, 0, "R9");
    endtask

    task automatic t_full_pattern();
        logic [31:0] s;
        s = 32'h1234_5678;
        for (int w = 0; w < 8; w++) begin
            s = s * 32'd1664525 + 32'd1013904223;
            write_word(w, s);
        end
        run_op(1'b0, 255, 0, "R9");
    endtask

    task automatic t_idle();
        run_op(1'b1, 8, 0, "R4");
        run_op(1'b1, 1, 0, "R4");
    endtask

    task automatic t_zero();
        run_op(1'b0, 0, 0, "R6");
        run_op(1'b1, 0, 0, "R6");
    endtask

    task automatic t_busy_start();
        write_word(0, 32'h000C_3A5F);
        run_op(1'b0, 20, 11, "R7");
        run_op(1'b1, 6, 5, "R7");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_short_pattern();
        t_cross_word();
        t_full_pattern();
        t_idle();
        t_zero();
        t_busy_start();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule